// File: doc/BRIEF.md
# Power-Fail Protected Byte SRAM

This block is a clocked model of a byte-wide nonvolatile static RAM. By default it holds 2048 bytes. It decodes read and write cycles from three active-low strobes: chip select, write strobe and output strobe. It replaces a tristate data bus with a data output plus a separate drive-enable flag. All strobes, the address and the write data are sampled on the rising clock edge.

Two digital supply-status flags stand in for an analog supply monitor. One flag reports that the supply is above the full-function level. The other reports that it is below the protect trip level. While the supply is faulted, the block ignores every input, never drives its output and never changes the array. A write in flight when a fault arrives is dropped. Access comes back only once the supply is good again and chip select has been seen inactive. The array is never cleared, so its contents survive a supply fault.

A write is committed only after the overlap of chip select and write strobe has ended. This mirrors how a strobed asynchronous RAM latches its data at the trailing edge of the write pulse.

Top module: `nvsram_guard`

## Requirements
- R1: The array stores 2**AW words of DW bits (default 2048 x 8). A committed write changes only the addressed word. A later read of any address returns the last byte committed there.
- R2: If a rising edge samples `cs_n`=0, `oe_n`=0 and `wr_n`=1 in normal operation, then after that edge `rd_valid`=1 and `rd_data` holds the word at the sampled address.
- R3: A write cycle is the run of rising edges that sample `cs_n`=0 and `wr_n`=0. The address used is the one sampled on the last edge of that run. The commit happens on the second edge after the last overlap edge, using `wr_data` sampled on that commit edge.
- R4: If an edge samples `wr_n`=0, then `rd_valid`=0 after that edge, whatever `cs_n` and `oe_n` are.
- R5: If an edge samples `sup_low`=1, then `rd_valid`=0 after that edge, and no write strobed during the fault changes the array.
- R6: After `sup_low` clears, the block stays protected until `sup_good`=1. It then returns to normal operation only on an edge that samples `sup_good`=1 and `cs_n`=1. Until then `rd_valid` stays 0.
- R7: If `sup_low`=1 on any edge after a write's overlap and up to its commit edge, that write is discarded and the array keeps its old word.
- R8: Words stored before a supply fault read back unchanged after recovery.
- R9: When `rd_valid`=0, `rd_data` is 0 (default option ZERO_IDLE=1).
- R10: During reset `rd_valid`=0 and `rd_data`=0. Reset leaves the block in the recovery state, so access starts only after an edge samples `sup_good`=1 and `cs_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | AW | Word address |
| wr_data | input | DW | Write data |
| sup_good | input | 1 | Supply above full-function level |
| sup_low | input | 1 | Supply below protect trip level |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | Read data is being driven |

## Verification
There are two ways a wrong protection state can show at the ports. If the state machine is stuck in normal operation during a fault, `rd_valid` rises on the first read edge of the fault. If it is stuck in protection, `rd_valid` fails to rise on the first read after recovery. Both show within one clock. A wrong write-pending flag shows only later. It appears on the next read of the affected address, as a lost byte, a byte written during a fault, or a byte written with data from the wrong cycle. For that reason the random traffic reads back every address it has written.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL  = 2'd0,
      ST_PROTECT = 2'd1,
      ST_RECOVER = 2'd2
   } prot_state_t;
endpackage

// File: rtl/nvsram_supply_fsm.sv
module nvsram_supply_fsm
   import nvsram_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sup_good,
   input  logic        sup_low,
   input  logic        cs_n,
   output prot_state_t state,
   output logic        access_en
);
   prot_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_NORMAL:  if (sup_low) nxt = ST_PROTECT;
         ST_PROTECT: if (!sup_low && sup_good) nxt = ST_RECOVER;
         ST_RECOVER: begin
            if (sup_low)               nxt = ST_PROTECT;
            else if (sup_good && cs_n) nxt = ST_NORMAL;
         end
         default:    nxt = ST_PROTECT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RECOVER;
      else        state <= nxt;
   end

   // a fault cuts access at once, before the state register follows
   assign access_en = (state == ST_NORMAL) && !sup_low;
endmodule

// File: rtl/nvsram_strobe.sv
module nvsram_strobe #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          access_en,
   input  logic          cs_n,
   input  logic          wr_n,
   input  logic [AW-1:0] addr,
   output logic          wr_fire,
   output logic [AW-1:0] wr_addr
);
   logic overlap_now;
   logic overlap_q;
   logic pend_q;

   assign overlap_now = !cs_n && !wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overlap_q <= 1'b0;
         pend_q    <= 1'b0;
         wr_addr   <= '0;
      end else begin
         overlap_q <= access_en && overlap_now;
         pend_q    <= access_en && overlap_q && !overlap_now;
         if (access_en && overlap_now) wr_addr <= addr;
      end
   end

   assign wr_fire = pend_q && access_en;
endmodule

// File: rtl/nvsram_array.sv
module nvsram_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      rd <= mem[ra];
   end
endmodule

// File: rtl/nvsram_guard.sv
module nvsram_guard
   import nvsram_pkg::*;
#(
   parameter int AW        = 11,
   parameter int DW        = 8,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          wr_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   input  logic          sup_good,
   input  logic          sup_low,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);
   generate
      if (AW < 1 || AW > 16) begin : g_bad_aw
         $error("nvsram_guard: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("nvsram_guard: DW must be positive");
      end
   endgenerate

   prot_state_t   state;
   logic          access_en;
   logic          mem_we;
   logic [AW-1:0] mem_wa;
   logic [DW-1:0] mem_rd;
   logic          drive_q;

   nvsram_supply_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .sup_good(sup_good), .sup_low(sup_low),
      .cs_n(cs_n), .state(state), .access_en(access_en)
   );

   nvsram_strobe #(.AW(AW)) u_strb (
      .clk(clk), .rst_n(rst_n), .access_en(access_en), .cs_n(cs_n),
      .wr_n(wr_n), .addr(addr), .wr_fire(mem_we), .wr_addr(mem_wa)
   );

   nvsram_array #(.AW(AW), .DW(DW)) u_mem (
      .clk(clk), .we(mem_we), .wa(mem_wa), .wd(wr_data),
      .ra(addr), .rd(mem_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drive_q <= 1'b0;
      else        drive_q <= access_en && !cs_n && !oe_n && wr_n;
   end

   assign rd_valid = drive_q;

   generate
      if (ZERO_IDLE) begin : g_zero
         assign rd_data = drive_q ? mem_rd : '0;
      end else begin : g_raw
         assign rd_data = mem_rd;
      end
   endgenerate
endmodule

// File: rtl/nvsram_guard_chk.sv
module nvsram_guard_chk
   import nvsram_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        wr_n,
   input logic        oe_n,
   input logic        sup_good,
   input logic        sup_low,
   input logic        rd_valid,
   input logic        mem_we,
   input prot_state_t state
);
   AST_WR_MUTES_OUT: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(wr_n)); // R4
   AST_READ_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(!cs_n && !oe_n)); // R2
   AST_FAULT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n) $past(sup_low) |-> !rd_valid); // R5
   AST_COMMIT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> $past(cs_n || wr_n)); // R3
   AST_NO_COMMIT_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !sup_low); // R7
   AST_RECOVER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NORMAL && $past(state) == ST_RECOVER) |-> $past(sup_good && cs_n)); // R6
endmodule

bind nvsram_guard nvsram_guard_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n),
   .sup_good(sup_good), .sup_low(sup_low), .rd_valid(rd_valid),
   .mem_we(mem_we), .state(state)
);

// File: tb/sim_nvsram_guard.sv
module sim_nvsram_guard;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b0, wr_n = 1'b1, oe_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          sup_good = 1'b1, sup_low = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [DEPTH];
   bit            known [DEPTH];

   nvsram_guard #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .oe_n(oe_n),
      .addr(addr), .wr_data(wr_data), .sup_good(sup_good), .sup_low(sup_low),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] pattern(input int i);
      return DW'((i * 37 + 11) ^ (i >> 3));
   endfunction

   task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      cs_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
   endtask

   // one overlap edge, then data held through the commit edge
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic oe, input bit update, input string req);
      addr = a; wr_data = d; cs_n = 1'b0; wr_n = 1'b0; oe_n = oe;
      tick();
      chk(req, {rd_valid, rd_data}, {1'b0, {DW{1'b0}}});
      idle();
      tick();
      tick();
      if (update) begin model[a] = d; known[a] = 1'b1; end
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string req);
      addr = a; cs_n = 1'b0; wr_n = 1'b1; oe_n = 1'b0;
      tick();
      if (known[a]) chk(req, {rd_valid, rd_data}, {1'b1, model[a]});
      else          chk(req, {DW'(0), rd_valid}, {DW'(0), 1'b1});
      idle();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
      tick();
      chk("R10 reset", {rd_valid, rd_data}, {1'b0, {DW{1'b0}}});
      rst_n = 1'b1;
      // chip select still low: recovery must hold off access
      tick(); tick();
      chk("R10 held in recovery", {DW'(0), rd_valid}, {DW'(0), 1'b0});
      idle();
      tick();

      for (int i = 0; i < 8; i++) do_write(AW'(i * 251), pattern(i), 1'b1, 1'b1, "R3 write");
      do_write(AW'(DEPTH - 1), 8'hA5, 1'b0, 1'b1, "R4 write with oe low");
      for (int i = 0; i < 8; i++) do_read(AW'(i * 251), "R1 readback");
      do_read(AW'(DEPTH - 1), "R1 top address");
      tick();
      chk("R9 idle zero", {rd_valid, rd_data}, {1'b0, {DW{1'b0}}});

      // R3: commit uses data present on the commit edge
      addr = 11'd100; wr_data = 8'h11; cs_n = 1'b0; wr_n = 1'b0;
      tick();
      idle(); wr_data = 8'h22;
      tick();
      wr_data = 8'h33;
      tick();
      wr_data = 8'h44;
      model[100] = 8'h33; known[100] = 1'b1;
      do_read(11'd100, "R3 commit-edge data");

      // R5/R6/R8: fault, ignored accesses, hysteresis
      sup_low = 1'b1; sup_good = 1'b0;
      addr = 11'd100; cs_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1;
      tick();
      chk("R5 fault floats", {DW'(0), rd_valid}, {DW'(0), 1'b0});
      do_write(11'd100, 8'hEE, 1'b1, 1'b0, "R5 write in fault");
      sup_low = 1'b0;
      cs_n = 1'b0; oe_n = 1'b0;
      tick(); tick();
      chk("R6 hysteresis", {DW'(0), rd_valid}, {DW'(0), 1'b0});
      sup_good = 1'b1;
      tick(); tick(); tick();
      chk("R6 cs low blocks", {DW'(0), rd_valid}, {DW'(0), 1'b0});
      idle();
      tick();
      do_read(11'd100, "R8 retained");
      do_read(11'd0, "R8 retained 0");

      // R7: fault between overlap end and commit aborts the write
      addr = 11'd251; wr_data = 8'h77; cs_n = 1'b0; wr_n = 1'b0;
      tick();
      idle(); sup_low = 1'b1; sup_good = 1'b0;
      tick(); tick();
      sup_low = 1'b0; sup_good = 1'b1;
      tick(); tick();
      do_read(11'd251, "R7 aborted write");

      // constrained random traffic over a small window plus wide addresses
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] a;
         a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 24);
         if ($urandom % 2) do_write(a, DW'($urandom), 1'($urandom), 1'b1, "R1 random write");
         else              do_read(a, "R2 random read");
      end
      for (int i = 0; i < 24; i++) do_read(AW'(i), "R1 final sweep");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule